// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the divider settings of a PLL clock synthesizer: a 9-bit feedback divider value, a 2-bit post-divide select and a 3-bit test-multiplexer select. Two independent paths can write these settings. A three-wire serial path shifts a 14-bit word into a shift register and commits it when its load strobe falls. A parallel path presents the divider value and the post-divide select on pins and commits them when its load strobe rises. While the parallel strobe is low, the parallel pins steer the configuration continuously.

Every strobe, the serial clock and the serial data are treated as asynchronous. Each one passes through its own synchronizer into the single system clock domain. Edge detection then turns the strobes into one-cycle events. A control module turns those events into a small struct of strobes that drives a datapath module, which holds the shift register and the configuration registers. The post-divide select is presented as a one-hot ratio vector, so bit k set means divide by 2^k.

Top module: `pll_cfg_loader`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `cfgM` reads 0x1FF, `divRatio` reads 4'b1000 (divide by 8) and `testSel` reads 0. `rst` also clears the shift register.
- R2: The shift register advances by one bit on each synchronized rising edge of `serClk`, taking `serData` as its new least significant bit. It never moves at any other time.
- R3: A synchronized falling edge of `serLoad` commits the last 14 bits shifted, as long as `parLoad` is high. The word is shifted most significant bit first. Bits 13:11 go to `testSel`, bits 10:9 to the post-divide select and bits 8:0 to `cfgM`, so the bit of `cfgM` with weight 1 is the last bit shifted.
- R4: A rising edge of `serLoad` leaves all outputs unchanged.
- R5: A synchronized rising edge of `parLoad` captures `parM` into `cfgM` and `parN` into the post-divide select, and leaves `testSel` unchanged. Pin changes after that edge have no effect while `parLoad` stays high.
- R6: While the synchronized `parLoad` is low, `cfgM` and the post-divide select follow `parM` and `parN`, and serial loads are ignored.
- R7: The post-divide select encoding is 00 for divide by 1, 01 for divide by 2, 10 for divide by 4 and 11 for divide by 8. `divRatio` is one-hot with bit 0, 1, 2 or 3 set for these four ratios respectively.
- R8: If a serial load edge and a parallel load edge reach the core in the same system cycle, only the parallel values are taken. No field of the serial word is committed, `testSel` included.
- R9: When more than 14 bits are shifted before a load, only the last 14 bits shifted are committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serData | input | 1 | Serial configuration data, asynchronous |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serLoad | input | 1 | Serial commit strobe; commits on its falling edge |
| parLoad | input | 1 | Parallel commit strobe; captures on its rising edge, tracks the pins while low |
| parM | input | 9 | Parallel feedback divider value |
| parN | input | 2 | Parallel post-divide select |
| cfgM | output | 9 | Registered feedback divider value |
| divRatio | output | 4 | One-hot post-divide ratio (bit k set = divide by 2^k) |
| testSel | output | 3 | Registered test-multiplexer select |

## Verification
The bench builds the block with its default widths (9-bit divider, 2-bit post-divide select, 3-bit test select) and two synchronizer stages. These widths give a 14-bit serial word and a 4-bit ratio vector, so every one of the four ratio codes and every field boundary of the word can be hit directly. The short synchronizer keeps edge-to-output latency at a few cycles. That makes it cheap to toggle the serial clock slowly, to overshift by two bits, and to line up a serial load edge and a parallel load edge so that they reach the core in the same cycle.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  // Strobes that the control module hands to the datapath each cycle.
  typedef struct packed {
    logic shiftEn;   // advance the shift register
    logic shiftBit;  // synchronized serial data for the shift
    logic serLoad;   // commit the shift register to the config registers
    logic parLoad;   // one-cycle parallel capture
    logic parTrack;  // parallel strobe held low: follow the pins
  } cfgStrobes_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic synced
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/cfg_control.sv
module cfg_control
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        serData,
  input  logic        serClk,
  input  logic        serLoad,
  input  logic        parLoad,
  output cfgStrobes_t strb
);
  // Input order: 0 data, 1 shift clock, 2 serial load, 3 parallel load.
  localparam int         NUM_IN   = 4;
  localparam logic [3:0] RST_VALS = 4'b1000;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] lvl;
  logic [NUM_IN-1:1] lvlPrev;

  assign rawIn = {parLoad, serLoad, serClk, serData};

  for (genvar i = 0; i < NUM_IN; i++) begin : g_sync
    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RST_VALS[i])) sync_i (
      .clk    (clk),
      .rst    (rst),
      .asyncIn(rawIn[i]),
      .synced (lvl[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) lvlPrev <= RST_VALS[NUM_IN-1:1];
    else     lvlPrev <= lvl[NUM_IN-1:1];
  end

  logic clkRise, serFall, parRise;
  assign clkRise = lvl[1] & ~lvlPrev[1];
  assign serFall = ~lvl[2] & lvlPrev[2];
  assign parRise = lvl[3] & ~lvlPrev[3];

  always_comb begin
    strb.shiftEn  = clkRise;
    strb.shiftBit = lvl[0];
    strb.parTrack = ~lvl[3];
    strb.parLoad  = parRise;
    // Parallel path wins: blocked while tracking and on a same-cycle capture.
    strb.serLoad  = serFall & lvl[3] & ~parRise;
  end
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import synth_cfg_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cfgStrobes_t          strb,
  input  logic [M_W-1:0]       parM,
  input  logic [N_W-1:0]       parN,
  output logic [M_W+N_W+T_W-1:0] shiftWord,
  output logic [M_W-1:0]       cfgM,
  output logic [(1<<N_W)-1:0]  divRatio,
  output logic [T_W-1:0]       testSel
);
  localparam int SHIFT_W = M_W + N_W + T_W;
  localparam int RATIO_W = 1 << N_W;

  logic [SHIFT_W-1:0] shiftReg;
  logic [N_W-1:0]     cfgN;

  always_ff @(posedge clk) begin
    if (rst)               shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[SHIFT_W-2:0], strb.shiftBit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgM    <= '1;
      cfgN    <= '1;
      testSel <= '0;
    end else if (strb.parTrack || strb.parLoad) begin
      cfgM <= parM;
      cfgN <= parN;
    end else if (strb.serLoad) begin
      {testSel, cfgN, cfgM} <= shiftReg;
    end
  end

  always_comb begin
    divRatio       = '0;
    divRatio[cfgN] = 1'b1;
  end

  assign shiftWord = shiftReg;

  logic unusedRatioW;
  assign unusedRatioW = (RATIO_W == 0);
endmodule

// File: rtl/pll_cfg_loader.sv
module pll_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int M_W         = 9,
  parameter int N_W         = 2,
  parameter int T_W         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                serData,
  input  logic                serClk,
  input  logic                serLoad,
  input  logic                parLoad,
  input  logic [M_W-1:0]      parM,
  input  logic [N_W-1:0]      parN,
  output logic [M_W-1:0]      cfgM,
  output logic [(1<<N_W)-1:0] divRatio,
  output logic [T_W-1:0]      testSel
);
  localparam int SHIFT_W = M_W + N_W + T_W;

  cfgStrobes_t        strb;
  logic [SHIFT_W-1:0] shiftWord;

  cfg_control #(.SYNC_STAGES(SYNC_STAGES)) control_i (
    .clk    (clk),
    .rst    (rst),
    .serData(serData),
    .serClk (serClk),
    .serLoad(serLoad),
    .parLoad(parLoad),
    .strb   (strb)
  );

  cfg_datapath #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) datapath_i (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .parM     (parM),
    .parN     (parN),
    .shiftWord(shiftWord),
    .cfgM     (cfgM),
    .divRatio (divRatio),
    .testSel  (testSel)
  );
endmodule

// File: rtl/pll_cfg_loader_chk.sv
module pll_cfg_loader_chk
  import synth_cfg_pkg::*;
#(
  parameter int M_W = 9,
  parameter int N_W = 2,
  parameter int T_W = 3
) (
  input logic                    clk,
  input logic                    rst,
  input cfgStrobes_t             strb,
  input logic [M_W+N_W+T_W-1:0]  shiftWord,
  input logic [M_W-1:0]          parM,
  input logic [M_W-1:0]          cfgM,
  input logic [(1<<N_W)-1:0]     divRatio,
  input logic [T_W-1:0]          testSel
);
  localparam int SHIFT_W = M_W + N_W + T_W;

  assert_reset_values_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfgM == '1 && divRatio[(1<<N_W)-1] && testSel == '0));

  assert_shift_only_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    !strb.shiftEn |=> $stable(shiftWord));

  assert_serial_commit_R3: assert property (@(posedge clk) disable iff (rst)
    strb.serLoad |=> (testSel == $past(shiftWord[SHIFT_W-1 -: T_W]) &&
                      cfgM == $past(shiftWord[M_W-1:0])));

  assert_test_sel_only_serial_R4: assert property (@(posedge clk) disable iff (rst)
    !strb.serLoad |=> $stable(testSel));

  assert_parallel_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (strb.parLoad || strb.parTrack) |=> cfgM == $past(parM));

  assert_track_blocks_serial_R6: assert property (@(posedge clk) disable iff (rst)
    strb.parTrack |-> !strb.serLoad);

  assert_ratio_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(divRatio) == 1);

  assert_parallel_priority_R8: assert property (@(posedge clk) disable iff (rst)
    strb.parLoad |-> !strb.serLoad);
endmodule

bind pll_cfg_loader pll_cfg_loader_chk #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .strb     (strb),
  .shiftWord(shiftWord),
  .parM     (parM),
  .cfgM     (cfgM),
  .divRatio (divRatio),
  .testSel  (testSel)
);

// File: tb/pll_cfg_loader_tb_top.sv
module pll_cfg_loader_tb_top;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int RATIO_W = 1 << N_W;
  localparam int SW      = M_W + N_W + T_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serData = 1'b0, serClk = 1'b0, serLoad = 1'b0, parLoad = 1'b1;
  logic [M_W-1:0] parM = '1;
  logic [N_W-1:0] parN = '1;
  logic [M_W-1:0] cfgM;
  logic [RATIO_W-1:0] divRatio;
  logic [T_W-1:0] testSel;

  always #10 clk = ~clk;  // 50 MHz

  pll_cfg_loader #(.M_W(M_W), .N_W(N_W), .T_W(T_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .serData(serData), .serClk(serClk), .serLoad(serLoad),
    .parLoad(parLoad), .parM(parM), .parN(parN),
    .cfgM(cfgM), .divRatio(divRatio), .testSel(testSel)
  );

  typedef struct {
    logic [M_W-1:0]     m;
    logic [RATIO_W-1:0] r;
    logic [T_W-1:0]     t;
    string              tag;
  } expItem_t;

  expItem_t   scoreQ[$];
  event       doCheck;
  int         tests = 0;
  int         fails = 0;
  bit         done  = 0;
  logic [M_W-1:0] expM;
  logic [N_W-1:0] expN;
  logic [T_W-1:0] expT;

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushExp(string tag);
    expItem_t e;
    e.m   = expM;
    e.r   = RATIO_W'(1) << expN;
    e.t   = expT;
    e.tag = tag;
    scoreQ.push_back(e);
    -> doCheck;
    waitClk(2);
  endtask

  // Monitor: pops one expected item per request and compares at a negedge.
  initial begin
    forever begin
      @(doCheck);
      @(negedge clk);
      while (scoreQ.size() > 0) begin
        expItem_t e;
        bit bad;
        e   = scoreQ.pop_front();
        bad = 0;
        tests++;
        if (cfgM !== e.m) begin
          $display("FAIL %s: cfgM actual %h expected %h", e.tag, cfgM, e.m); bad = 1;
        end
        if (divRatio !== e.r) begin
          $display("FAIL %s: divRatio actual %b expected %b", e.tag, divRatio, e.r); bad = 1;
        end
        if (testSel !== e.t) begin
          $display("FAIL %s: testSel actual %h expected %h", e.tag, testSel, e.t); bad = 1;
        end
        if (bad) fails++;
      end
    end
  end

  task automatic shiftBits(logic [31:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = bits[i];
      waitClk(3);
      serClk = 1'b1;
      waitClk(3);
      serClk = 1'b0;
      waitClk(1);
    end
  endtask

  task automatic serPulse();
    serLoad = 1'b1;
    waitClk(8);
    serLoad = 1'b0;
    waitClk(8);
  endtask

  task automatic loadWord(logic [T_W-1:0] t, logic [N_W-1:0] n, logic [M_W-1:0] m);
    shiftBits(32'({t, n, m}), SW);
    serPulse();
  endtask

  initial begin
    waitClk(4);
    rst = 1'b0;
    waitClk(6);
    // R1: reset state
    expM = '1; expN = '1; expT = '0;
    pushExp("R1 reset values");

    // R2, R3, R4, R7: serial word T=5 N=01 M=0A5
    shiftBits(32'({3'd5, 2'b01, 9'h0A5}), SW);
    serLoad = 1'b1;
    waitClk(8);
    pushExp("R4 rising serial load no effect");
    serLoad = 1'b0;
    waitClk(8);
    expM = 9'h0A5; expN = 2'b01; expT = 3'd5;
    pushExp("R3 serial commit, R7 N=01 divide by 2");

    loadWord(3'd2, 2'b00, 9'h1C3);
    expM = 9'h1C3; expN = 2'b00; expT = 3'd2;
    pushExp("R7 N=00 divide by 1, R2 shift");

    loadWord(3'd7, 2'b10, 9'h001);
    expM = 9'h001; expN = 2'b10; expT = 3'd7;
    pushExp("R7 N=10 divide by 4, R3 last bit is M lsb");

    // R9: overshift by two ones
    shiftBits(32'({2'b11, 3'd1, 2'b11, 9'h000}), SW + 2);
    serPulse();
    expM = 9'h000; expN = 2'b11; expT = 3'd1;
    pushExp("R9 only last 14 bits kept, R7 N=11");

    // R6: tracking while parallel strobe low
    parM = 9'h123; parN = 2'b10;
    parLoad = 1'b0;
    waitClk(8);
    expM = 9'h123; expN = 2'b10;
    pushExp("R6 tracking parallel pins");
    parM = 9'h055; parN = 2'b01;
    waitClk(8);
    expM = 9'h055; expN = 2'b01;
    pushExp("R6 follows pin change");
    loadWord(3'd4, 2'b00, 9'h0F0);
    pushExp("R6 serial load ignored while parallel low");

    // R5: rising edge capture then hold
    parM = 9'h1AA; parN = 2'b11;
    waitClk(4);
    parLoad = 1'b1;
    waitClk(8);
    expM = 9'h1AA; expN = 2'b11;
    pushExp("R5 parallel capture, T unchanged");
    parM = 9'h033; parN = 2'b00;
    waitClk(8);
    pushExp("R5 pins ignored after capture");

    loadWord(3'd3, 2'b01, 9'h0FF);
    expM = 9'h0FF; expN = 2'b01; expT = 3'd3;
    pushExp("R3 serial load after parallel capture");

    // R8: simultaneous serial and parallel load edges
    parLoad = 1'b0;
    waitClk(8);
    expM = 9'h033; expN = 2'b00;
    pushExp("R6 tracking before collision");
    shiftBits(32'({3'd6, 2'b11, 9'h155}), SW);
    serLoad = 1'b1;
    parM = 9'h0AB; parN = 2'b10;
    waitClk(8);
    serLoad = 1'b0;
    parLoad = 1'b1;
    waitClk(8);
    expM = 9'h0AB; expN = 2'b10;
    pushExp("R8 parallel wins same-cycle collision");

    // R1: mid-run reset
    rst = 1'b1;
    waitClk(3);
    expM = '1; expN = '1; expT = '0;
    pushExp("R1 reset held");
    rst = 1'b0;
    waitClk(1);
    pushExp("R1 after reset release");

    waitClk(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual still running, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule